// File: doc/BRIEF.md
# Virtual Exclusion Line Power Controller

This block manages the supply state of every line of a small, direct-mapped L2 tag array that sits below a private L1. Each line has a tag, a valid flag, a dirty flag and an inclusion flag. The inclusion flag is set while the L1 also holds the line. While it is set, the L2 copy of the data is idle, so the controller places that line's data array in a low-voltage retention supply. The line goes back to normal supply as soon as the L1 gives the line up.

Inclusion stays exact. The L1 reports every eviction, clean ones as well, so the inclusion flag can be cleared. When a bus snoop hits a line held in the L1, the controller forwards the snoop to the L1 and does not answer it from the L2 data. A core write to an L1-resident line sends a write notice, and the L2 then records the line as dirty. An L2 lookup reports a hit or a miss, together with its access cost in cycles. That cost is higher when the line is in retention. A miss allocates the new tag. If the replaced line was held in the L1, the controller sends a back-invalidation to the L1.

The controller takes one event per cycle and applies a fixed priority. Events that lose in the same cycle are dropped, so the surrounding logic presents an event again if it must be handled.

Top module: `vx_line_power_ctl`

## Requirements
- R1: After reset, and again after any later reset, every line is invalid with inclusion clear, `supply_low` is all zero, and every pulse output is 0.
- R2: An L2 lookup raises `lk_done` one cycle later. `lk_hit` is 1 when the line is valid and its stored tag equals `lk_tag`. On a miss the line gets the new tag, is valid, and has dirty and inclusion clear.
- R3: An L1 fill of a valid line sets its inclusion flag. Its `supply_low` bit rises one cycle after the inclusion flag, which is two clock edges after the fill. A fill of an invalid line is ignored.
- R4: An L1 eviction of a line with inclusion set clears the inclusion flag. On the same edge, `supply_low` for that line returns to 0. If `ev_dirty` is 1, the L2 dirty flag is set.
- R5: A read snoop (`snp_inv`=0) that hits a line with inclusion set raises `fwd_valid` with `fwd_inv`=0 and `fwd_idx` equal to the line. The line state and its supply are left unchanged.
- R6: An invalidating snoop (`snp_inv`=1) that hits a line with inclusion set raises `fwd_valid` with `fwd_inv`=1. It clears valid, dirty and inclusion, and `supply_low` for the line falls on the same edge.
- R7: Every snoop raises `snp_resp_valid` one cycle later, with `snp_resp_hit` (valid and tag match) and `snp_resp_dirty` (hit and dirty). A hit on a line with inclusion clear raises no forward. If that snoop is invalidating, the line becomes invalid.
- R8: A write notice on a valid line with inclusion set sets the dirty flag. A write notice on a line with inclusion clear is ignored.
- R9: Only one event is taken per cycle. The order is snoop, then eviction, then fill, then write notice, then lookup. Events that lose are dropped with no effect.
- R10: A lookup miss on a line with inclusion set raises `fwd_valid` with `fwd_inv`=1 and `fwd_idx` equal to the line. The new line starts with inclusion clear and normal supply.
- R11: `lk_cycles` is 12 when the line's `supply_low` bit is 1 at the time of the lookup, and 10 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Bus snoop present |
| snp_inv | input | 1 | 1: invalidating snoop, 0: read snoop |
| snp_idx | input | IDX_W | Snoop line index |
| snp_tag | input | TAG_W | Snoop tag |
| ev_valid | input | 1 | L1 eviction notice |
| ev_idx | input | IDX_W | Evicted line index |
| ev_dirty | input | 1 | Evicted L1 copy was modified |
| fill_valid | input | 1 | L1 fill event |
| fill_idx | input | IDX_W | Filled line index |
| wr_valid | input | 1 | L1 write notice |
| wr_idx | input | IDX_W | Written line index |
| lk_valid | input | 1 | L2 lookup request |
| lk_idx | input | IDX_W | Lookup line index |
| lk_tag | input | TAG_W | Lookup tag |
| supply_low | output | NUM_LINES | Per-line retention supply select (1 = low voltage) |
| fwd_valid | output | 1 | Request to the L1 for a forwarded snoop |
| fwd_inv | output | 1 | Forwarded request invalidates the L1 copy |
| fwd_idx | output | IDX_W | Line index of the forwarded request |
| snp_resp_valid | output | 1 | Snoop result present |
| snp_resp_hit | output | 1 | Snoop matched a valid L2 line |
| snp_resp_dirty | output | 1 | Matched line was dirty |
| lk_done | output | 1 | Lookup result present |
| lk_hit | output | 1 | Lookup hit |
| lk_cycles | output | LAT_W | Access cost of the lookup in cycles |

## Verification
Every event is registered once. Its pulse outputs (`lk_done`, `snp_resp_*`, `fwd_*`) are therefore due one edge after the event is driven. A rising `supply_low` bit needs a second edge, because it follows the inclusion flag. A falling bit comes with the first edge. The bench drives each event at a falling clock edge and samples the pulses at the next falling edge. It then waits one more edge with idle inputs before it samples the line's supply bit, so a rise and a fall are both settled when they are read. The priority cases drive several events in the same cycle. After that cycle, the bench checks the supply bit and the snoop or lookup results, which show whether a losing event touched the line.

// File: rtl/vx_pkg.sv
package vx_pkg;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_SNOOP  = 3'd1,
        EV_EVICT  = 3'd2,
        EV_FILL   = 3'd3,
        EV_WRITE  = 3'd4,
        EV_LOOKUP = 3'd5
    } ev_kind_e;

endpackage

// File: rtl/vx_event_arb.sv
module vx_event_arb #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic               snp_valid,
    input  logic               snp_inv,
    input  logic [IDX_W-1:0]   snp_idx,
    input  logic [TAG_W-1:0]   snp_tag,
    input  logic               ev_valid,
    input  logic [IDX_W-1:0]   ev_idx,
    input  logic               ev_dirty,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic               wr_valid,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               lk_valid,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic [TAG_W-1:0]   lk_tag,
    output vx_pkg::ev_kind_e   sel_kind,
    output logic [IDX_W-1:0]   sel_idx,
    output logic [TAG_W-1:0]   sel_tag,
    output logic               sel_flag
);
    import vx_pkg::*;

    // Fixed priority: snoop > eviction > fill > write notice > lookup (R9)
    always_comb begin
        sel_kind = EV_NONE;
        sel_idx  = '0;
        sel_tag  = '0;
        sel_flag = 1'b0;
        if (snp_valid) begin
            sel_kind = EV_SNOOP;
            sel_idx  = snp_idx;
            sel_tag  = snp_tag;
            sel_flag = snp_inv;
        end else if (ev_valid) begin
            sel_kind = EV_EVICT;
            sel_idx  = ev_idx;
            sel_flag = ev_dirty;
        end else if (fill_valid) begin
            sel_kind = EV_FILL;
            sel_idx  = fill_idx;
        end else if (wr_valid) begin
            sel_kind = EV_WRITE;
            sel_idx  = wr_idx;
        end else if (lk_valid) begin
            sel_kind = EV_LOOKUP;
            sel_idx  = lk_idx;
            sel_tag  = lk_tag;
        end
    end

endmodule

// File: rtl/vx_tag_store.sv
module vx_tag_store #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 8,
    parameter int LAT_W     = 4,
    parameter int LAT_NORM  = 10,
    parameter int LAT_LOW   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  vx_pkg::ev_kind_e      sel_kind,
    input  logic [IDX_W-1:0]      sel_idx,
    input  logic [TAG_W-1:0]      sel_tag,
    input  logic                  sel_flag,
    input  logic [NUM_LINES-1:0]  pwr_low,
    output logic [NUM_LINES-1:0]  incl_q,
    output logic [NUM_LINES-1:0]  incl_d,
    output logic                  fwd_valid,
    output logic                  fwd_inv,
    output logic [IDX_W-1:0]      fwd_idx,
    output logic                  sr_valid,
    output logic                  sr_hit,
    output logic                  sr_dirty,
    output logic                  lk_done,
    output logic                  lk_hit,
    output logic [LAT_W-1:0]      lk_cycles
);
    import vx_pkg::*;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             valid;
        logic             dirty;
        logic             incl;
    } line_t;

    typedef struct packed {
        line_t [NUM_LINES-1:0] lines;
        logic                  fwd_valid;
        logic                  fwd_inv;
        logic [IDX_W-1:0]      fwd_idx;
        logic                  sr_valid;
        logic                  sr_hit;
        logic                  sr_dirty;
        logic                  lk_done;
        logic                  lk_hit;
        logic [LAT_W-1:0]      lk_cyc;
    } state_t;

    state_t st_d, st_q;
    line_t  cur;
    logic   tag_hit;

    always_comb begin
        st_d           = st_q;
        st_d.fwd_valid = 1'b0;
        st_d.fwd_inv   = 1'b0;
        st_d.fwd_idx   = '0;
        st_d.sr_valid  = 1'b0;
        st_d.sr_hit    = 1'b0;
        st_d.sr_dirty  = 1'b0;
        st_d.lk_done   = 1'b0;
        st_d.lk_hit    = 1'b0;
        st_d.lk_cyc    = '0;

        cur     = st_q.lines[sel_idx];
        tag_hit = cur.valid && (cur.tag == sel_tag);

        unique case (sel_kind)
            EV_SNOOP: begin
                st_d.sr_valid = 1'b1;
                st_d.sr_hit   = tag_hit;
                st_d.sr_dirty = tag_hit && cur.dirty;
                if (tag_hit && cur.incl) begin
                    st_d.fwd_valid = 1'b1;
                    st_d.fwd_inv   = sel_flag;
                    st_d.fwd_idx   = sel_idx;
                end
                if (tag_hit && sel_flag) begin
                    cur.valid = 1'b0;
                    cur.dirty = 1'b0;
                    cur.incl  = 1'b0;
                end
            end
            EV_EVICT: begin
                if (cur.valid && cur.incl) begin
                    cur.incl  = 1'b0;
                    cur.dirty = cur.dirty | sel_flag;
                end
            end
            EV_FILL: begin
                if (cur.valid) begin
                    cur.incl = 1'b1;
                end
            end
            EV_WRITE: begin
                if (cur.valid && cur.incl) begin
                    cur.dirty = 1'b1;
                end
            end
            EV_LOOKUP: begin
                st_d.lk_done = 1'b1;
                st_d.lk_hit  = tag_hit;
                st_d.lk_cyc  = pwr_low[sel_idx] ? LAT_W'(LAT_LOW) : LAT_W'(LAT_NORM);
                if (!tag_hit) begin
                    if (cur.valid && cur.incl) begin
                        st_d.fwd_valid = 1'b1;
                        st_d.fwd_inv   = 1'b1;
                        st_d.fwd_idx   = sel_idx;
                    end
                    cur.tag   = sel_tag;
                    cur.valid = 1'b1;
                    cur.dirty = 1'b0;
                    cur.incl  = 1'b0;
                end
            end
            default: ;
        endcase

        st_d.lines[sel_idx] = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            incl_q[i] = st_q.lines[i].incl;
            incl_d[i] = st_d.lines[i].incl;
        end
    end

    assign fwd_valid = st_q.fwd_valid;
    assign fwd_inv   = st_q.fwd_inv;
    assign fwd_idx   = st_q.fwd_idx;
    assign sr_valid  = st_q.sr_valid;
    assign sr_hit    = st_q.sr_hit;
    assign sr_dirty  = st_q.sr_dirty;
    assign lk_done   = st_q.lk_done;
    assign lk_hit    = st_q.lk_hit;
    assign lk_cycles = st_q.lk_cyc;

endmodule

// File: rtl/vx_supply_ctl.sv
module vx_supply_ctl #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] incl_q,
    input  logic [NUM_LINES-1:0] incl_d,
    output logic [NUM_LINES-1:0] pwr_low
);
    typedef struct packed {
        logic [NUM_LINES-1:0] low;
    } pwr_t;

    pwr_t pw_d, pw_q;

    // A line drops only after inclusion has been set for a full cycle,
    // and it rises back on the edge where inclusion clears.
    always_comb begin
        pw_d = pw_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            pw_d.low[i] = incl_q[i] & incl_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_q <= '0;
        end else begin
            pw_q <= pw_d;
        end
    end

    assign pwr_low = pw_q.low;

endmodule

// File: rtl/vx_line_power_ctl.sv
module vx_line_power_ctl #(
    parameter int NUM_LINES  = 16,
    parameter int TAG_W      = 8,
    parameter int LAT_NORM   = 10,
    parameter int LAT_LOW    = 12,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int LAT_W     = $clog2(LAT_LOW + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  snp_valid,
    input  logic                  snp_inv,
    input  logic [IDX_W-1:0]      snp_idx,
    input  logic [TAG_W-1:0]      snp_tag,
    input  logic                  ev_valid,
    input  logic [IDX_W-1:0]      ev_idx,
    input  logic                  ev_dirty,
    input  logic                  fill_valid,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic                  wr_valid,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  lk_valid,
    input  logic [IDX_W-1:0]      lk_idx,
    input  logic [TAG_W-1:0]      lk_tag,
    output logic [NUM_LINES-1:0]  supply_low,
    output logic                  fwd_valid,
    output logic                  fwd_inv,
    output logic [IDX_W-1:0]      fwd_idx,
    output logic                  snp_resp_valid,
    output logic                  snp_resp_hit,
    output logic                  snp_resp_dirty,
    output logic                  lk_done,
    output logic                  lk_hit,
    output logic [LAT_W-1:0]      lk_cycles
);
    vx_pkg::ev_kind_e     sel_kind;
    logic [IDX_W-1:0]     sel_idx;
    logic [TAG_W-1:0]     sel_tag;
    logic                 sel_flag;
    logic [NUM_LINES-1:0] incl_vec;
    logic [NUM_LINES-1:0] incl_nxt;

    vx_event_arb #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_arb (
        .snp_valid (snp_valid),
        .snp_inv   (snp_inv),
        .snp_idx   (snp_idx),
        .snp_tag   (snp_tag),
        .ev_valid  (ev_valid),
        .ev_idx    (ev_idx),
        .ev_dirty  (ev_dirty),
        .fill_valid(fill_valid),
        .fill_idx  (fill_idx),
        .wr_valid  (wr_valid),
        .wr_idx    (wr_idx),
        .lk_valid  (lk_valid),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .sel_kind  (sel_kind),
        .sel_idx   (sel_idx),
        .sel_tag   (sel_tag),
        .sel_flag  (sel_flag)
    );

    vx_tag_store #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .LAT_W(LAT_W), .LAT_NORM(LAT_NORM), .LAT_LOW(LAT_LOW)
    ) i_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_kind (sel_kind),
        .sel_idx  (sel_idx),
        .sel_tag  (sel_tag),
        .sel_flag (sel_flag),
        .pwr_low  (supply_low),
        .incl_q   (incl_vec),
        .incl_d   (incl_nxt),
        .fwd_valid(fwd_valid),
        .fwd_inv  (fwd_inv),
        .fwd_idx  (fwd_idx),
        .sr_valid (snp_resp_valid),
        .sr_hit   (snp_resp_hit),
        .sr_dirty (snp_resp_dirty),
        .lk_done  (lk_done),
        .lk_hit   (lk_hit),
        .lk_cycles(lk_cycles)
    );

    vx_supply_ctl #(.NUM_LINES(NUM_LINES)) i_supply (
        .clk    (clk),
        .rst_n  (rst_n),
        .incl_q (incl_vec),
        .incl_d (incl_nxt),
        .pwr_low(supply_low)
    );

endmodule

// File: rtl/vx_lpc_checker.sv
module vx_lpc_checker #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int LAT_W     = 4,
    parameter int LAT_NORM  = 10,
    parameter int LAT_LOW   = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 snp_valid,
    input logic [IDX_W-1:0]     snp_idx,
    input logic                 ev_valid,
    input logic [IDX_W-1:0]     ev_idx,
    input logic                 fill_valid,
    input logic                 wr_valid,
    input logic                 lk_valid,
    input logic [NUM_LINES-1:0] supply_low,
    input logic [NUM_LINES-1:0] incl_vec,
    input logic                 fwd_valid,
    input logic [IDX_W-1:0]     fwd_idx,
    input logic                 snp_resp_valid,
    input logic                 lk_done,
    input logic [LAT_W-1:0]     lk_cycles
);

    // R3: a line never sits at low supply without inclusion
    a_r3_low_needs_incl: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_low & ~incl_vec) == '0);

    // R3: supply drops only after inclusion was already set the cycle before
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_rise
        a_r3_rise_after_incl: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(supply_low[g]) |-> $past(incl_vec[g]));
    end

    // R4: an eviction that wins arbitration leaves the line at normal supply
    a_r4_evict_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !snp_valid) |=> !supply_low[$past(ev_idx)]);

    // R5: a forward raised by a snoop names the snooped line
    a_r5_fwd_index: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && $past(snp_valid)) |-> fwd_idx == $past(snp_idx));

    // R7: a snoop response follows a snoop
    a_r7_resp_from_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snp_resp_valid |-> $past(snp_valid));

    // R9: a lookup result only when the lookup had no competitor
    a_r9_lookup_alone: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> $past(lk_valid && !snp_valid && !ev_valid && !fill_valid && !wr_valid));

    // R9: one event per cycle, so never two kinds of result together
    a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_done && snp_resp_valid));

    // R11: lookup cost is one of the two supply-dependent values
    a_r11_cost_values: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> (lk_cycles == LAT_W'(LAT_NORM) || lk_cycles == LAT_W'(LAT_LOW)));

endmodule

bind vx_line_power_ctl vx_lpc_checker #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .LAT_W(LAT_W),
    .LAT_NORM(LAT_NORM), .LAT_LOW(LAT_LOW)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .snp_valid     (snp_valid),
    .snp_idx       (snp_idx),
    .ev_valid      (ev_valid),
    .ev_idx        (ev_idx),
    .fill_valid    (fill_valid),
    .wr_valid      (wr_valid),
    .lk_valid      (lk_valid),
    .supply_low    (supply_low),
    .incl_vec      (incl_vec),
    .fwd_valid     (fwd_valid),
    .fwd_idx       (fwd_idx),
    .snp_resp_valid(snp_resp_valid),
    .lk_done       (lk_done),
    .lk_cycles     (lk_cycles)
);

// File: tb/test_vx_line_power_ctl.sv
`timescale 1ns/1ps
module test_vx_line_power_ctl;

    localparam int NL = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        snp_valid, snp_inv, ev_valid, ev_dirty, fill_valid, wr_valid, lk_valid;
    logic [3:0]  snp_idx, ev_idx, fill_idx, wr_idx, lk_idx;
    logic [7:0]  snp_tag, lk_tag;
    logic [NL-1:0] supply_low;
    logic        fwd_valid, fwd_inv, snp_resp_valid, snp_resp_hit, snp_resp_dirty;
    logic        lk_done, lk_hit;
    logic [3:0]  fwd_idx, lk_cycles;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vx_line_power_ctl i_vx_line_power_ctl (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_idx(snp_idx), .snp_tag(snp_tag),
        .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_dirty(ev_dirty),
        .fill_valid(fill_valid), .fill_idx(fill_idx),
        .wr_valid(wr_valid), .wr_idx(wr_idx),
        .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_tag(lk_tag),
        .supply_low(supply_low),
        .fwd_valid(fwd_valid), .fwd_inv(fwd_inv), .fwd_idx(fwd_idx),
        .snp_resp_valid(snp_resp_valid), .snp_resp_hit(snp_resp_hit),
        .snp_resp_dirty(snp_resp_dirty),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_cycles(lk_cycles)
    );

    // operation codes used by the vector table
    localparam logic [2:0] OP_SR = 3'd0;  // read snoop
    localparam logic [2:0] OP_SI = 3'd1;  // invalidating snoop
    localparam logic [2:0] OP_EV = 3'd2;  // L1 eviction (flag = dirty)
    localparam logic [2:0] OP_FL = 3'd3;  // L1 fill
    localparam logic [2:0] OP_WR = 3'd4;  // L1 write notice
    localparam logic [2:0] OP_LK = 3'd5;  // L2 lookup

    typedef struct packed {
        logic [2:0] op;
        logic [3:0] idx;
        logic [7:0] tag;
        logic       flag;
        logic       done;
        logic       hit;
        logic [3:0] cyc;
        logic       fwd;
        logic       finv;
        logic       sresp;
        logic       shit;
        logic       sdirty;
        logic       sup;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    //                         op     idx  tag    fl done hit cyc  fwd finv sr shit sdty sup req
    localparam vec_t VECS [NV] = '{
        '{OP_LK, 4'd3, 8'hA5, 1'b0, 1'b1, 1'b0, 4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 miss allocates
        '{OP_LK, 4'd3, 8'hA5, 1'b0, 1'b1, 1'b1, 4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 hit, normal
        '{OP_FL, 4'd3, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 fill -> low
        '{OP_LK, 4'd3, 8'hA5, 1'b0, 1'b1, 1'b1, 4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11}, // R11 hit, retention
        '{OP_SR, 4'd3, 8'hA5, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 forward read
        '{OP_WR, 4'd3, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 write notice
        '{OP_EV, 4'd3, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 clean evict
        '{OP_SR, 4'd3, 8'hA5, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 dirty kept, R7 no fwd
        '{OP_FL, 4'd5, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 fill invalid ignored
        '{OP_LK, 4'd5, 8'h3C, 1'b0, 1'b1, 1'b0, 4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 miss
        '{OP_WR, 4'd5, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 write w/o incl
        '{OP_SR, 4'd5, 8'h3C, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 still clean
        '{OP_FL, 4'd5, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
        '{OP_EV, 4'd5, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 dirty evict
        '{OP_SR, 4'd5, 8'h3C, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 dirty seen
        '{OP_FL, 4'd5, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
        '{OP_SI, 4'd5, 8'h3C, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 forward invalidate
        '{OP_LK, 4'd5, 8'h3C, 1'b0, 1'b1, 1'b0, 4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 line gone
        '{OP_SR, 4'd9, 8'h77, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 snoop miss
        '{OP_SI, 4'd3, 8'hA5, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 L2 answers inv
        '{OP_LK, 4'd3, 8'hA5, 1'b0, 1'b1, 1'b0, 4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 invalidated
        '{OP_FL, 4'd3, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
        '{OP_LK, 4'd3, 8'h11, 1'b0, 1'b1, 1'b0, 4'd12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 back-invalidate
        '{OP_SR, 4'd3, 8'h11, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10}  // R10 new line clean
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        snp_valid = 0; snp_inv = 0; snp_idx = 0; snp_tag = 0;
        ev_valid = 0; ev_idx = 0; ev_dirty = 0;
        fill_valid = 0; fill_idx = 0;
        wr_valid = 0; wr_idx = 0;
        lk_valid = 0; lk_idx = 0; lk_tag = 0;
    endtask

    task automatic drive(input logic [2:0] op, input logic [3:0] idx,
                         input logic [7:0] tag, input logic flag);
        case (op)
            OP_SR, OP_SI: begin
                snp_valid = 1; snp_inv = (op == OP_SI); snp_idx = idx; snp_tag = tag;
            end
            OP_EV: begin ev_valid = 1; ev_idx = idx; ev_dirty = flag; end
            OP_FL: begin fill_valid = 1; fill_idx = idx; end
            OP_WR: begin wr_valid = 1; wr_idx = idx; end
            default: begin lk_valid = 1; lk_idx = idx; lk_tag = tag; end
        endcase
    endtask

    task automatic check_quiet(input string req);
        check(req, "lk_done", int'(lk_done), 0);
        check(req, "snp_resp_valid", int'(snp_resp_valid), 0);
        check(req, "fwd_valid", int'(fwd_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        check("R1", "supply_low", int'(supply_low), 0);
        check_quiet("R1");
        check("R1", "fwd_inv", int'(fwd_inv), 0);

        // Vector table: drive, sample pulses one edge later, supply one more edge later
        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[v].req);
            drive(VECS[v].op, VECS[v].idx, VECS[v].tag, VECS[v].flag);
            @(negedge clk);
            idle();
            check(rq, "lk_done", int'(lk_done), int'(VECS[v].done));
            if (VECS[v].done) begin
                check(rq, "lk_hit", int'(lk_hit), int'(VECS[v].hit));
                check(rq, "lk_cycles", int'(lk_cycles), int'(VECS[v].cyc));
            end
            check(rq, "fwd_valid", int'(fwd_valid), int'(VECS[v].fwd));
            if (VECS[v].fwd) begin
                check(rq, "fwd_inv", int'(fwd_inv), int'(VECS[v].finv));
                check(rq, "fwd_idx", int'(fwd_idx), int'(VECS[v].idx));
            end
            check(rq, "snp_resp_valid", int'(snp_resp_valid), int'(VECS[v].sresp));
            if (VECS[v].sresp) begin
                check(rq, "snp_resp_hit", int'(snp_resp_hit), int'(VECS[v].shit));
                check(rq, "snp_resp_dirty", int'(snp_resp_dirty), int'(VECS[v].sdirty));
            end
            @(negedge clk);
            check(rq, "supply_low[idx]", int'(supply_low[VECS[v].idx]), int'(VECS[v].sup));
        end

        // R9: fill beats lookup on line 5 (valid, tag 3C, inclusion clear)
        drive(OP_FL, 4'd5, 8'h00, 1'b0);
        drive(OP_LK, 4'd5, 8'h3C, 1'b0);
        @(negedge clk); idle();
        check("R9", "lk_done fill+lookup", int'(lk_done), 0);
        @(negedge clk);
        check("R9", "supply after fill+lookup", int'(supply_low[5]), 1);

        // R9: snoop beats eviction; supply stays low
        drive(OP_SR, 4'd5, 8'h3C, 1'b0);
        drive(OP_EV, 4'd5, 8'h00, 1'b1);
        @(negedge clk); idle();
        check("R9", "fwd_valid snoop+evict", int'(fwd_valid), 1);
        check("R9", "snp_resp_dirty snoop+evict", int'(snp_resp_dirty), 0);
        @(negedge clk);
        check("R9", "supply after snoop+evict", int'(supply_low[5]), 1);

        // R9: eviction beats fill and write notice
        drive(OP_EV, 4'd5, 8'h00, 1'b0);
        drive(OP_FL, 4'd5, 8'h00, 1'b0);
        drive(OP_WR, 4'd5, 8'h00, 1'b0);
        @(negedge clk); idle();
        @(negedge clk);
        check("R9", "supply after evict+fill", int'(supply_low[5]), 0);
        drive(OP_SR, 4'd5, 8'h3C, 1'b0);
        @(negedge clk); idle();
        check("R9", "dirty after evict+write", int'(snp_resp_dirty), 0);
        check("R9", "no fwd after evict+fill", int'(fwd_valid), 0);
        @(negedge clk);

        // R1: reset in mid-run clears state
        drive(OP_FL, 4'd3, 8'h00, 1'b0);
        @(negedge clk); idle();
        @(negedge clk);
        check("R1", "supply before reset", int'(supply_low[3]), 1);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R1", "supply after reset", int'(supply_low), 0);
        check_quiet("R1");
        drive(OP_LK, 4'd3, 8'h11, 1'b0);
        @(negedge clk); idle();
        check("R1", "lk_hit after reset", int'(lk_hit), 0);
        check("R1", "fwd after reset lookup", int'(fwd_valid), 0);
        @(negedge clk);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule